// File: doc/BRIEF.md
# Per-Device Row Address Scrambler

Several memory devices together hold one error-correcting codeword. This block takes one logical row address and gives each device its own physical row address. It scrambles the address once with a secret four-round balanced Feistel network. It then rotates the result by an amount fixed for each lane: lane k rotates left by k bit positions. Each lane's map is a bijection. Two rows that sit next to each other in one device are never next to each other in any other device. A disturbance aimed at one physical neighbourhood therefore reaches only one device's share of each codeword.

The block is a pipeline. Each Feistel round has its own register stage, and one more stage applies the lane rotations. Each stage can accept a new address on every clock. The Feistel stage can be bypassed so that the rotation layer can be tested by itself. An inverse mode maps a physical row of a chosen device back to its logical row, so the mapping can be confirmed by a round trip. The key register can be written but never read out. A key write takes effect only when no address is being accepted and no address is in flight, so every transaction uses one key from start to finish.

Top module: `row_scrambler`

## Requirements
- R1: Every address accepted with `in_valid` high produces exactly one `out_valid` pulse, ROUNDS+1 clocks later (5 with the defaults). Addresses may be presented on consecutive clocks.
- R2: In forward mode, lane k of `out_rows` (bits `[k*ROW_W +: ROW_W]`) equals the Feistel result rotated left by k bit positions. Lane 0 is not rotated.
- R3: The Feistel result is computed as follows. Split the address into hi (upper ROW_W/2 bits) and lo (lower half). For rounds i = 0 to ROUNDS-1, replace (hi, lo) with (lo, hi XOR S(lo XOR K_i)). The subkey K_i is `key_in` bits `[i*ROW_W/2 +: ROW_W/2]` of the stored key. S replaces each 4-bit nibble v with entry v of the table 6,B,0,9,D,3,E,4,8,F,2,7,1,C,5,A (hex, for v = 0 to 15). The result is {hi, lo}.
- R4: For a fixed key, each lane maps the 2^ROW_W logical rows onto 2^ROW_W distinct physical rows.
- R5: Take two logical rows whose physical rows differ by exactly one in some lane j. In every other lane, their physical rows do not differ by one.
- R6: With `in_bypass` high, no Feistel rounds are applied. In forward mode, lane k is the input address rotated left by k.
- R7: With `in_inv` high, the input is treated as a physical row of device `in_dev`, which must be less than NDEV. The block rotates the input right by `in_dev`, then undoes the Feistel rounds with the subkeys in reverse order, or undoes none of them when `in_bypass` is high. Every lane then shows the recovered logical row. A forward map followed by the inverse returns the original address.
- R8: A `key_we` pulse loads `key_in` when `in_valid` is low and no address is in flight. The next accepted address uses the new key.
- R9: A `key_we` pulse is ignored while `in_valid` is high or any address is in flight. Later addresses still use the old key.
- R10: Reset clears `out_valid`, all of `out_rows` and the stored key to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_we | input | 1 | Key write strobe |
| key_in | input | ROUNDS*ROW_W/2 | New key; subkey i is slice i |
| in_valid | input | 1 | Address strobe |
| in_row | input | ROW_W | Logical row (forward) or physical row (inverse) |
| in_inv | input | 1 | Inverse mapping select |
| in_bypass | input | 1 | Skip the Feistel rounds |
| in_dev | input | $clog2(NDEV) | Device whose physical row is inverted |
| out_valid | output | 1 | Result strobe |
| out_rows | output | NDEV*ROW_W | One physical (or recovered logical) row per lane |

## Verification
The assertions assume three things about the inputs:
- Reset is held for at least one clock before any traffic.
- `in_dev` stays below NDEV whenever inverse mode is used.
- Mode bits are meaningful only in cycles where `in_valid` is high.

The stimulus keeps to these assumptions. It holds reset for several clocks and uses device indices 0 to 3 only. It drives mode bits together with each valid address.

To exercise the key-hold rule on purpose, the stimulus issues a key write in two situations:
- in the same cycle as a valid address;
- one cycle after a burst, while the pipeline is still full.

It then checks that later results still follow the old key. The bijection and adjacency properties are checked exhaustively over all 256 rows of the 8-bit default.

// File: rtl/rscr_pkg.sv
package rscr_pkg;

  // Fixed 4-bit substitution applied to every nibble of a round input.
  function automatic logic [3:0] sbox4(input logic [3:0] v);
    logic [3:0] r;
    case (v)
      4'h0: r = 4'h6;  4'h1: r = 4'hB;  4'h2: r = 4'h0;  4'h3: r = 4'h9;
      4'h4: r = 4'hD;  4'h5: r = 4'h3;  4'h6: r = 4'hE;  4'h7: r = 4'h4;
      4'h8: r = 4'h8;  4'h9: r = 4'hF;  4'hA: r = 4'h2;  4'hB: r = 4'h7;
      4'hC: r = 4'h1;  4'hD: r = 4'hC;  4'hE: r = 4'h5;  default: r = 4'hA;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rscr_keyreg.sv
module rscr_keyreg #(
  parameter int KW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          hold,
  input  logic [KW-1:0] din,
  output logic [KW-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)             q <= '0;
    else if (we && !hold) q <= din;
  end

  // R9: no key change while an address is accepted or in flight
  a_r9_key_frozen: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(q));

  // R8: an idle write lands in one clock
  a_r8_key_load: assert property (@(posedge clk) disable iff (rst)
    (we && !hold) |=> (q == $past(din)));

endmodule

// File: rtl/rscr_round.sv
module rscr_round
  import rscr_pkg::*;
#(
  parameter int H = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         i_valid,
  input  logic         i_inv,
  input  logic         i_byp,
  input  logic [H-1:0] i_hi,
  input  logic [H-1:0] i_lo,
  input  logic [H-1:0] i_sk,
  output logic         o_valid,
  output logic         o_inv,
  output logic         o_byp,
  output logic [H-1:0] o_hi,
  output logic [H-1:0] o_lo
);

  localparam int NIB = H / 4;

  logic [H-1:0] f_in, f_out, n_hi, n_lo;

  always_comb begin
    // Forward rounds mix the low half into the high half; inverse reverses that.
    f_in  = (i_inv ? i_hi : i_lo) ^ i_sk;
    f_out = '0;
    for (int n = 0; n < NIB; n++) f_out[n*4 +: 4] = sbox4(f_in[n*4 +: 4]);
    if (i_byp) begin
      n_hi = i_hi;
      n_lo = i_lo;
    end else if (i_inv) begin
      n_hi = i_lo ^ f_out;
      n_lo = i_hi;
    end else begin
      n_hi = i_lo;
      n_lo = i_hi ^ f_out;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_inv   <= 1'b0;
      o_byp   <= 1'b0;
      o_hi    <= '0;
      o_lo    <= '0;
    end else begin
      o_valid <= i_valid;
      o_inv   <= i_inv;
      o_byp   <= i_byp;
      o_hi    <= n_hi;
      o_lo    <= n_lo;
    end
  end

  // R1: each stage advances a valid by exactly one clock
  a_r1_stage_adv: assert property (@(posedge clk) disable iff (rst)
    i_valid |=> o_valid);
  a_r1_stage_idle: assert property (@(posedge clk) disable iff (rst)
    !i_valid |=> !o_valid);

  // R6: a bypassed transaction leaves the halves untouched
  a_r6_round_pass: assert property (@(posedge clk) disable iff (rst)
    (i_valid && i_byp) |=> (o_hi == $past(i_hi) && o_lo == $past(i_lo)));

  // R7: an inverse transaction stays inverse down the pipe
  a_r7_mode_kept: assert property (@(posedge clk) disable iff (rst)
    i_valid |=> (o_inv == $past(i_inv)));

endmodule

// File: rtl/rscr_lanes.sv
module rscr_lanes #(
  parameter int R    = 8,
  parameter int NDEV = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            i_valid,
  input  logic            i_inv,
  input  logic [R-1:0]    i_row,
  output logic            o_valid,
  output logic [NDEV*R-1:0] o_rows
);

  logic [2*R-1:0] dbl_in;
  logic           o_inv;

  assign dbl_in = {i_row, i_row};

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_inv   <= 1'b0;
    end else begin
      o_valid <= i_valid;
      o_inv   <= i_inv;
    end
  end

  for (genvar k = 0; k < NDEV; k++) begin : g_lane
    logic [R-1:0] rot;
    assign rot = i_inv ? i_row : dbl_in[2*R-1-k -: R];

    always_ff @(posedge clk) begin
      if (rst) o_rows[k*R +: R] <= '0;
      else     o_rows[k*R +: R] <= rot;
    end

    if (k > 0) begin : g_chk
      logic [2*R-1:0] dbl0;
      assign dbl0 = {o_rows[R-1:0], o_rows[R-1:0]};

      // R2: lane k is lane 0 turned left by k
      a_r2_lane_rot: assert property (@(posedge clk) disable iff (rst)
        (o_valid && !o_inv) |-> (o_rows[k*R +: R] == dbl0[2*R-1-k -: R]));

      // R7: every lane carries the same recovered row
      a_r7_lane_same: assert property (@(posedge clk) disable iff (rst)
        (o_valid && o_inv) |-> (o_rows[k*R +: R] == o_rows[R-1:0]));
    end
  end

endmodule

// File: rtl/row_scrambler.sv
module row_scrambler #(
  parameter int ROW_W  = 8,
  parameter int NDEV   = 4,
  parameter int ROUNDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          key_we,
  input  logic [ROUNDS*(ROW_W/2)-1:0]   key_in,
  input  logic                          in_valid,
  input  logic [ROW_W-1:0]              in_row,
  input  logic                          in_inv,
  input  logic                          in_bypass,
  input  logic [$clog2(NDEV)-1:0]       in_dev,
  output logic                          out_valid,
  output logic [NDEV*ROW_W-1:0]         out_rows
);

  localparam int H     = ROW_W / 2;
  localparam int KEY_W = ROUNDS * H;

  if (ROW_W % 8 != 0) begin : g_bad_width
    $error("ROW_W must be a multiple of 8");
  end
  if (NDEV < 2 || NDEV > ROW_W) begin : g_bad_ndev
    $error("NDEV must lie between 2 and ROW_W");
  end

  logic [KEY_W-1:0]   key_q;
  logic               busy, hold;
  logic [2*ROW_W-1:0] unrot_dbl;
  logic [ROW_W-1:0]   entry_row;

  logic         st_v   [ROUNDS+1];
  logic         st_inv [ROUNDS+1];
  logic         st_byp [ROUNDS+1];
  logic [H-1:0] st_hi  [ROUNDS+1];
  logic [H-1:0] st_lo  [ROUNDS+1];
  logic         unused_byp;

  // Inverse mode undoes the device rotation before the rounds.
  assign unrot_dbl = {in_row, in_row} >> in_dev;
  assign entry_row = in_inv ? unrot_dbl[ROW_W-1:0] : in_row;

  assign st_v[0]   = in_valid;
  assign st_inv[0] = in_inv;
  assign st_byp[0] = in_bypass;
  assign st_hi[0]  = entry_row[ROW_W-1:H];
  assign st_lo[0]  = entry_row[H-1:0];

  always_comb begin
    busy = 1'b0;
    for (int i = 1; i <= ROUNDS; i++) busy = busy | st_v[i];
  end
  assign hold = in_valid | busy;

  rscr_keyreg #(.KW(KEY_W)) u_key (
    .clk  (clk),
    .rst  (rst),
    .we   (key_we),
    .hold (hold),
    .din  (key_in),
    .q    (key_q)
  );

  for (genvar i = 0; i < ROUNDS; i++) begin : g_round
    logic [H-1:0] sk;
    assign sk = st_inv[i] ? key_q[(ROUNDS-1-i)*H +: H] : key_q[i*H +: H];

    rscr_round #(.H(H)) u_rnd (
      .clk     (clk),
      .rst     (rst),
      .i_valid (st_v[i]),
      .i_inv   (st_inv[i]),
      .i_byp   (st_byp[i]),
      .i_hi    (st_hi[i]),
      .i_lo    (st_lo[i]),
      .i_sk    (sk),
      .o_valid (st_v[i+1]),
      .o_inv   (st_inv[i+1]),
      .o_byp   (st_byp[i+1]),
      .o_hi    (st_hi[i+1]),
      .o_lo    (st_lo[i+1])
    );
  end

  assign unused_byp = st_byp[ROUNDS];

  rscr_lanes #(.R(ROW_W), .NDEV(NDEV)) u_lanes (
    .clk     (clk),
    .rst     (rst),
    .i_valid (st_v[ROUNDS]),
    .i_inv   (st_inv[ROUNDS]),
    .i_row   ({st_hi[ROUNDS], st_lo[ROUNDS]}),
    .o_valid (out_valid),
    .o_rows  (out_rows)
  );

  // R10: nothing comes out in the cycle after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_rows == '0));

endmodule

// File: tb/sim_row_scrambler.sv
module sim_row_scrambler;
  localparam int CLK_PERIOD = 10;
  localparam int RW = 8;
  localparam int ND = 4;
  localparam int NR = 4;
  localparam int LAT = NR + 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_we = 1'b0;
  logic [15:0] key_in = '0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_row = '0;
  logic        in_inv = 1'b0;
  logic        in_bypass = 1'b0;
  logic [1:0]  in_dev = '0;
  logic        out_valid;
  logic [31:0] out_rows;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_rows [4096];
  int          exp_req  [4096];
  bit          exp_cap  [4096];
  int          exp_x    [4096];
  int wr_ptr = 0;
  int rd_ptr = 0;

  logic [7:0]  phys [4][256];
  logic [15:0] key_m = '0;

  row_scrambler #(.ROW_W(RW), .NDEV(ND), .ROUNDS(NR)) u0 (
    .clk(clk), .rst(rst), .key_we(key_we), .key_in(key_in),
    .in_valid(in_valid), .in_row(in_row), .in_inv(in_inv),
    .in_bypass(in_bypass), .in_dev(in_dev),
    .out_valid(out_valid), .out_rows(out_rows)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] sb(input logic [3:0] v);
    logic [3:0] t [16] = '{4'h6, 4'hB, 4'h0, 4'h9, 4'hD, 4'h3, 4'hE, 4'h4,
                           4'h8, 4'hF, 4'h2, 4'h7, 4'h1, 4'hC, 4'h5, 4'hA};
    return t[v];
  endfunction

  // R3 model: four rounds on 4-bit halves
  function automatic logic [7:0] feist(input logic [7:0] x, input logic [15:0] k);
    logic [3:0] hi, lo, t;
    hi = x[7:4]; lo = x[3:0];
    for (int i = 0; i < 4; i++) begin
      t  = hi ^ sb(lo ^ k[i*4 +: 4]);
      hi = lo;
      lo = t;
    end
    return {hi, lo};
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] x, input int k);
    logic [15:0] d;
    d = {x, x} << k;
    return d[15:8];
  endfunction

  function automatic logic [7:0] rotr(input logic [7:0] x, input int k);
    logic [15:0] d;
    d = {x, x} >> k;
    return d[7:0];
  endfunction

  function automatic logic [31:0] fwd_exp(input logic [7:0] x, input bit byp);
    logic [7:0] y;
    logic [31:0] e;
    y = byp ? x : feist(x, key_m);
    for (int k = 0; k < 4; k++) e[k*8 +: 8] = rotl(y, k);
    return e;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic send(input logic [7:0] row, input bit inv, input bit byp,
                      input int dev, input logic [31:0] e, input int req, input bit cap);
    exp_rows[wr_ptr] = e;
    exp_req[wr_ptr]  = req;
    exp_cap[wr_ptr]  = cap;
    exp_x[wr_ptr]    = int'(row);
    wr_ptr++;
    in_valid  = 1'b1;
    in_row    = row;
    in_inv    = inv;
    in_bypass = byp;
    in_dev    = 2'(dev);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic write_key(input logic [15:0] k);
    key_we = 1'b1;
    key_in = k;
    @(negedge clk);
    key_we = 1'b0;
  endtask

  // Output monitor: every result is matched in order against the bench model.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd_ptr >= wr_ptr) begin
        chk(1'b0, "R1 unexpected out_valid", 1, 0);
      end else begin
        chk(out_rows == exp_rows[rd_ptr], $sformatf("R%0d lanes", exp_req[rd_ptr]),
            out_rows, exp_rows[rd_ptr]);
        if (exp_cap[rd_ptr])
          for (int k = 0; k < 4; k++) phys[k][exp_x[rd_ptr]] = out_rows[k*8 +: 8];
        rd_ptr++;
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int cnt;
    int seen [4][256];
    logic [7:0] invt [4][256];
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(out_valid == 1'b0, "R10 valid", out_valid, 0);
    chk(out_rows == '0, "R10 rows", out_rows, 0);
    rst = 1'b0;
    @(negedge clk);

    // R10: key resets to zero, so the first result follows an all-zero key
    send(8'h5A, 0, 0, 0, fwd_exp(8'h5A, 0), 10, 0);
    idle(LAT + 2);

    write_key(16'hB47E);
    key_m = 16'hB47E;

    // R1: latency of one isolated address
    send(8'h3C, 0, 0, 0, fwd_exp(8'h3C, 0), 1, 0);
    in_valid = 1'b0;
    cnt = 1;
    while (!out_valid && cnt < 20) begin
      @(negedge clk);
      cnt++;
    end
    chk(cnt == LAT, "R1 latency", cnt, LAT);
    idle(LAT + 2);

    // R2, R3: full forward sweep, back to back
    for (int x = 0; x < 256; x++) send(8'(x), 0, 0, 0, fwd_exp(8'(x), 0), 2, 1);
    idle(LAT + 2);

    // R4: bijection per lane
    for (int k = 0; k < 4; k++) for (int v = 0; v < 256; v++) seen[k][v] = 0;
    for (int k = 0; k < 4; k++)
      for (int x = 0; x < 256; x++) begin
        seen[k][phys[k][x]]++;
        invt[k][phys[k][x]] = 8'(x);
      end
    for (int k = 0; k < 4; k++) begin
      int miss;
      miss = 0;
      for (int v = 0; v < 256; v++) if (seen[k][v] != 1) miss++;
      chk(miss == 0, $sformatf("R4 lane %0d distinct", k), miss, 0);
    end

    // R5: neighbours in one lane are not neighbours elsewhere
    for (int j = 0; j < 4; j++)
      for (int k = 0; k < 4; k++) begin
        int bad, d;
        if (k == j) continue;
        bad = 0;
        for (int p = 0; p < 255; p++) begin
          d = int'(phys[k][invt[j][p]]) - int'(phys[k][invt[j][p+1]]);
          if (d == 1 || d == -1) bad++;
        end
        chk(bad == 0, $sformatf("R5 lanes %0d/%0d adjacent pairs", j, k), bad, 0);
      end

    // R7: inverse of each device's physical rows returns the logical row
    for (int k = 0; k < 4; k++)
      for (int x = 0; x < 256; x++)
        send(phys[k][x], 1, 0, k, {4{8'(x)}}, 7, 0);
    // R7 with bypass: undo rotation only
    for (int k = 0; k < 4; k++)
      for (int x = 0; x < 256; x += 37)
        send(rotl(8'(x), k), 1, 1, k, {4{8'(x)}}, 7, 0);
    idle(LAT + 2);

    // R6: bypass sweep, rotation only
    for (int x = 0; x < 256; x++) send(8'(x), 0, 1, 0, fwd_exp(8'(x), 1), 6, 0);
    idle(LAT + 2);

    // R9: key writes while valid is high, then while the pipe is full
    key_we = 1'b1; key_in = 16'h29D1;
    send(8'h11, 0, 0, 0, fwd_exp(8'h11, 0), 9, 0);
    key_we = 1'b0;
    for (int x = 0; x < 7; x++) send(8'(x * 29), 0, 0, 0, fwd_exp(8'(x * 29), 0), 9, 0);
    in_valid = 1'b0;
    write_key(16'hE05C);
    idle(LAT + 2);
    for (int x = 0; x < 4; x++) send(8'(x * 53 + 7), 0, 0, 0, fwd_exp(8'(x * 53 + 7), 0), 9, 0);
    idle(LAT + 2);

    // R8: idle write takes effect on the very next address
    in_valid = 1'b0;
    write_key(16'h29D1);
    key_m = 16'h29D1;
    send(8'hC3, 0, 0, 0, fwd_exp(8'hC3, 0), 8, 0);
    send(8'h0F, 0, 0, 0, fwd_exp(8'h0F, 0), 8, 0);
    idle(LAT + 3);

    // R1: one output for every input
    chk(rd_ptr == wr_ptr, "R1 output count", rd_ptr, wr_ptr);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule